// File: doc/BRIEF.md
# Half-Word Multiply Execution Unit

This unit is the multiply slot of one VLIW issue lane. Each accepted request carries a 7-bit operation code and two 32-bit source operands. The operation code picks which 16-bit halves take part in the product. The choices are low by low, low by high, high by high, or the whole first operand against one half of the second. It also picks whether the chosen halves are sign-extended or zero-extended, and whether the product is moved up by 16 bit positions. The unit returns the low 32 bits of the product. Codes outside the multiply group give a zero result with an illegal-operation flag.

Requests enter and results leave over valid/ready handshakes. A request moves when `in_valid` and `in_ready` are both high at a rising clock edge. A result is taken when `out_valid` and `out_ready` are both high. The two internal pipeline registers advance together. They stall only when a result is waiting and the consumer holds `out_ready` low. While stalled, `in_ready` is low, the result held at the output does not change, and the producer must keep its request steady. No request is dropped or repeated. With no back-pressure the unit accepts one request per cycle, and each result appears two clock edges after its request is accepted.

Top module: `halfword_mul_unit`

## Requirements
- R1: Code 0000001 multiplies the low halves of both operands as signed values. Code 0000010 does the same as unsigned values.
- R2: Code 0000011 multiplies the low half of source 1 by the high half of source 2 as signed values. Code 0000100 does the same as unsigned values.
- R3: Code 0000101 multiplies the high halves of both operands as signed values. Code 0000110 does the same as unsigned values.
- R4: Code 0000111 multiplies all of source 1 by the sign-extended low half of source 2. Code 0001000 uses the zero-extended low half instead.
- R5: Code 0001001 multiplies all of source 1 by the sign-extended high half of source 2. Code 0001010 uses the zero-extended high half instead.
- R6: Code 0001011 multiplies all of source 1 by the sign-extended high half of source 2 and shifts the product left by 16. Bits 15:0 of its result are always zero.
- R7: Every result is the low 32 bits of the full product. Higher bits are dropped.
- R8: Codes 0001100 to 0001111, and every code outside 0000001 to 0001011, give a zero result with `out_illegal` high. Legal codes give `out_illegal` low.
- R9: After reset `out_valid` is low. With `out_ready` high, a request accepted at one edge shows its result with `out_valid` high after the next edge, and not before it.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output holds its result and flag unchanged. When the output is empty, `in_ready` is high.
- R11: Results leave in request order, one per accepted request. Back-to-back requests give back-to-back results, and idle cycles give no `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_opcode | input | 7 | Operation code |
| in_src1 | input | 32 | First source operand |
| in_src2 | input | 32 | Second source operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Truncated product |
| out_illegal | output | 1 | Request carried an unsupported code |

## Verification
A wrong choice of half or wrong extension in the first stage shows up as a wrong `out_result` two edges after the request is accepted. The bench uses operands whose halves differ and whose sign bits are set, so a swapped half or a wrong sign changes the value it reads. A valid bit stuck or lost between the stages shows up on `out_valid` within one or two edges, as a missing, early or extra result. A stall that leaks, where a register loads while the output is blocked, shows up as a held result that changes, or as a result that is skipped or repeated when `out_ready` returns.

// File: rtl/hmul_pkg.sv
package hmul_pkg;

  localparam int OPC_W = 7;

  localparam logic [OPC_W-1:0] OPC_LO_LO_S   = 7'b0000001;
  localparam logic [OPC_W-1:0] OPC_LO_LO_U   = 7'b0000010;
  localparam logic [OPC_W-1:0] OPC_LO_HI_S   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_LO_HI_U   = 7'b0000100;
  localparam logic [OPC_W-1:0] OPC_HI_HI_S   = 7'b0000101;
  localparam logic [OPC_W-1:0] OPC_HI_HI_U   = 7'b0000110;
  localparam logic [OPC_W-1:0] OPC_WD_LO_S   = 7'b0000111;
  localparam logic [OPC_W-1:0] OPC_WD_LO_U   = 7'b0001000;
  localparam logic [OPC_W-1:0] OPC_WD_HI_S   = 7'b0001001;
  localparam logic [OPC_W-1:0] OPC_WD_HI_U   = 7'b0001010;
  localparam logic [OPC_W-1:0] OPC_WD_HI_SHL = 7'b0001011;

  // Which part of source 1 feeds the multiplier
  typedef enum logic [1:0] {
    PICK1_LO   = 2'd0,
    PICK1_HI   = 2'd1,
    PICK1_WORD = 2'd2
  } pick1_e;

  // Which half of source 2 feeds the multiplier
  typedef enum logic {
    PICK2_LO = 1'b0,
    PICK2_HI = 1'b1
  } pick2_e;

  typedef struct packed {
    pick1_e pick1;
    pick2_e pick2;
    logic   sext;
    logic   shl;
    logic   illegal;
  } mul_ctrl_t;

endpackage

// File: rtl/hmul_decode.sv
module hmul_decode
  import hmul_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output mul_ctrl_t        ctrl
);

  always_comb begin
    ctrl = '{pick1: PICK1_LO, pick2: PICK2_LO, sext: 1'b0, shl: 1'b0, illegal: 1'b0};
    case (opcode)
      OPC_LO_LO_S:   begin ctrl.pick1 = PICK1_LO;   ctrl.pick2 = PICK2_LO; ctrl.sext = 1'b1; end
      OPC_LO_LO_U:   begin ctrl.pick1 = PICK1_LO;   ctrl.pick2 = PICK2_LO; end
      OPC_LO_HI_S:   begin ctrl.pick1 = PICK1_LO;   ctrl.pick2 = PICK2_HI; ctrl.sext = 1'b1; end
      OPC_LO_HI_U:   begin ctrl.pick1 = PICK1_LO;   ctrl.pick2 = PICK2_HI; end
      OPC_HI_HI_S:   begin ctrl.pick1 = PICK1_HI;   ctrl.pick2 = PICK2_HI; ctrl.sext = 1'b1; end
      OPC_HI_HI_U:   begin ctrl.pick1 = PICK1_HI;   ctrl.pick2 = PICK2_HI; end
      OPC_WD_LO_S:   begin ctrl.pick1 = PICK1_WORD; ctrl.pick2 = PICK2_LO; ctrl.sext = 1'b1; end
      OPC_WD_LO_U:   begin ctrl.pick1 = PICK1_WORD; ctrl.pick2 = PICK2_LO; end
      OPC_WD_HI_S:   begin ctrl.pick1 = PICK1_WORD; ctrl.pick2 = PICK2_HI; ctrl.sext = 1'b1; end
      OPC_WD_HI_U:   begin ctrl.pick1 = PICK1_WORD; ctrl.pick2 = PICK2_HI; end
      OPC_WD_HI_SHL: begin
        ctrl.pick1 = PICK1_WORD;
        ctrl.pick2 = PICK2_HI;
        ctrl.sext  = 1'b1;
        ctrl.shl   = 1'b1;
      end
      default:       ctrl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/hmul_half_ext.sv
module hmul_half_ext #(
  parameter int HALF_W = 16,
  parameter int OUT_W  = 32
) (
  input  logic [HALF_W-1:0] half_in,
  input  logic              sext,
  output logic [OUT_W-1:0]  ext_out
);

  localparam int PAD_W = OUT_W - HALF_W;

  logic fill;
  assign fill    = sext & half_in[HALF_W-1];
  assign ext_out = {{PAD_W{fill}}, half_in};

endmodule

// File: rtl/hmul_operand_sel.sv
module hmul_operand_sel
  import hmul_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2,
  input  pick1_e            pick1,
  input  pick2_e            pick2,
  input  logic              sext,
  output logic [DATA_W-1:0] mul_a,
  output logic [DATA_W-1:0] mul_b
);

  localparam int HALF_W  = DATA_W / 2;
  localparam int N_HALVES = 4;

  // Index 0/1: low/high half of src1, index 2/3: low/high half of src2
  logic [DATA_W-1:0] ext [N_HALVES];

  for (genvar g = 0; g < N_HALVES; g++) begin : g_half
    localparam int OFS = (g % 2) * HALF_W;
    logic [HALF_W-1:0] raw;
    if (g < 2) begin : g_src1
      assign raw = src1[OFS +: HALF_W];
    end else begin : g_src2
      assign raw = src2[OFS +: HALF_W];
    end
    hmul_half_ext #(.HALF_W(HALF_W), .OUT_W(DATA_W)) ext_i (
      .half_in (raw),
      .sext    (sext),
      .ext_out (ext[g])
    );
  end

  always_comb begin
    case (pick1)
      PICK1_LO: mul_a = ext[0];
      PICK1_HI: mul_a = ext[1];
      default:  mul_a = src1;
    endcase
    mul_b = (pick2 == PICK2_HI) ? ext[3] : ext[2];
  end

endmodule

// File: rtl/hmul_product.sv
module hmul_product #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] mul_a,
  input  logic [DATA_W-1:0] mul_b,
  input  logic              shl,
  input  logic              illegal,
  output logic [DATA_W-1:0] result
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] prod_lo;
  logic [DATA_W-1:0] prod_shl;

  // The low DATA_W product bits depend only on the low DATA_W operand bits
  assign prod_lo  = mul_a * mul_b;
  assign prod_shl = {prod_lo[DATA_W-HALF_W-1:0], {HALF_W{1'b0}}};

  always_comb begin
    if (illegal)  result = '0;
    else if (shl) result = prod_shl;
    else          result = prod_lo;
  end

endmodule

// File: rtl/halfword_mul_unit.sv
module halfword_mul_unit
  import hmul_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_opcode,
  input  logic [DATA_W-1:0] in_src1,
  input  logic [DATA_W-1:0] in_src2,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);

  localparam int HALF_W = DATA_W / 2;

  mul_ctrl_t         dec_ctrl;
  logic [DATA_W-1:0] sel_a;
  logic [DATA_W-1:0] sel_b;
  logic              advance;

  logic              s1_valid;
  logic [DATA_W-1:0] s1_a;
  logic [DATA_W-1:0] s1_b;
  logic              s1_shl;
  logic              s1_ill;
  logic [DATA_W-1:0] s2_result;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  hmul_decode dec_i (
    .opcode (in_opcode),
    .ctrl   (dec_ctrl)
  );

  hmul_operand_sel #(.DATA_W(DATA_W)) sel_i (
    .src1  (in_src1),
    .src2  (in_src2),
    .pick1 (dec_ctrl.pick1),
    .pick2 (dec_ctrl.pick2),
    .sext  (dec_ctrl.sext),
    .mul_a (sel_a),
    .mul_b (sel_b)
  );

  // Stage 1: extended operands and control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_a     <= '0;
      s1_b     <= '0;
      s1_shl   <= 1'b0;
      s1_ill   <= 1'b0;
    end else if (advance) begin
      s1_valid <= in_valid;
      s1_a     <= sel_a;
      s1_b     <= sel_b;
      s1_shl   <= dec_ctrl.shl;
      s1_ill   <= dec_ctrl.illegal;
    end
  end

  hmul_product #(.DATA_W(DATA_W)) prod_i (
    .mul_a   (s1_a),
    .mul_b   (s1_b),
    .shl     (s1_shl),
    .illegal (s1_ill),
    .result  (s2_result)
  );

  // Stage 2: output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else if (advance) begin
      out_valid   <= s1_valid;
      out_result  <= s2_result;
      out_illegal <= s1_ill;
    end
  end

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_result == '0); // R8

  AST_SHIFT_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    advance && s1_valid && s1_shl && !s1_ill |=> out_result[HALF_W-1:0] == '0); // R6

  AST_TWO_EDGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready |=> out_valid); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_illegal)); // R10

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R10

  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s1_valid)); // R11

endmodule

// File: tb/halfword_mul_unit_tb_top.sv
`timescale 1ns/1ps
module halfword_mul_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [6:0]  in_opcode = '0;
  logic [31:0] in_src1 = '0;
  logic [31:0] in_src2 = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  halfword_mul_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_opcode   (in_opcode),
    .in_src1     (in_src1),
    .in_src2     (in_src2),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_result  (out_result),
    .out_illegal (out_illegal)
  );

  // {req[3:0], op[6:0], src1[31:0], src2[31:0], expected[31:0], illegal}
  localparam int NV = 19;
  localparam logic [107:0] VECS [NV] = '{
    {4'd1,  7'b0000001, 32'h0000_FFFE, 32'h0000_0003, 32'hFFFF_FFFA, 1'b0},
    {4'd1,  7'b0000010, 32'h0000_FFFE, 32'h0000_0003, 32'h0002_FFFA, 1'b0},
    {4'd2,  7'b0000011, 32'h1234_0005, 32'hFFFF_0000, 32'hFFFF_FFFB, 1'b0},
    {4'd2,  7'b0000100, 32'h1234_0005, 32'hFFFF_0000, 32'h0004_FFFB, 1'b0},
    {4'd3,  7'b0000101, 32'h8000_0000, 32'h8000_1111, 32'h4000_0000, 1'b0},
    {4'd3,  7'b0000110, 32'hFFFF_0000, 32'hFFFF_0000, 32'hFFFE_0001, 1'b0},
    {4'd4,  7'b0000111, 32'h0000_0002, 32'h0000_FFFF, 32'hFFFF_FFFE, 1'b0},
    {4'd4,  7'b0001000, 32'h0000_0002, 32'h0000_FFFF, 32'h0001_FFFE, 1'b0},
    {4'd4,  7'b0000111, 32'hFFFF_FFFF, 32'h0000_0005, 32'hFFFF_FFFB, 1'b0},
    {4'd5,  7'b0001001, 32'h0000_0003, 32'hFFFE_0000, 32'hFFFF_FFFA, 1'b0},
    {4'd5,  7'b0001010, 32'h0000_0003, 32'hFFFE_0000, 32'h0002_FFFA, 1'b0},
    {4'd6,  7'b0001011, 32'h0000_0003, 32'hFFFE_1234, 32'hFFFA_0000, 1'b0},
    {4'd7,  7'b0000111, 32'h4000_0000, 32'h0000_0004, 32'h0000_0000, 1'b0},
    {4'd7,  7'b0001010, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'hFFFF_0001, 1'b0},
    {4'd7,  7'b0001011, 32'h0001_0001, 32'h0001_0000, 32'h0001_0000, 1'b0},
    {4'd8,  7'b0001100, 32'h0000_0005, 32'h0000_0007, 32'h0000_0000, 1'b1},
    {4'd8,  7'b0001111, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
    {4'd8,  7'b0000000, 32'h0000_0009, 32'h0000_0009, 32'h0000_0000, 1'b1},
    {4'd8,  7'b0010001, 32'h1234_5678, 32'h0000_0002, 32'h0000_0000, 1'b1}
  };

  function automatic string req_tag(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [6:0] op, input logic [31:0] a, input logic [31:0] b);
    in_valid  = 1'b1;
    in_opcode = op;
    in_src1   = a;
    in_src2   = b;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    @(negedge clk);
    tick();
    // Reset state (R9, R10)
    chk(out_valid == 1'b0, "R9", "out_valid in reset", {31'b0, out_valid}, 32'd0);
    chk(in_ready == 1'b1, "R10", "in_ready in reset", {31'b0, in_ready}, 32'd1);
    rst_n = 1'b1;
    tick();
    chk(out_valid == 1'b0, "R9", "out_valid after reset", {31'b0, out_valid}, 32'd0);

    // Vector walk, one request at a time
    for (int i = 0; i < NV; i++) begin
      logic [107:0] v;
      string        rt;
      v  = VECS[i];
      rt = req_tag(v[107:104]);
      drive(v[103:97], v[96:65], v[64:33]);
      tick();
      in_valid = 1'b0;
      chk(out_valid == 1'b0, "R9", "out_valid one edge after request", {31'b0, out_valid}, 32'd0);
      tick();
      chk(out_valid == 1'b1, "R9", "out_valid two edges after request", {31'b0, out_valid}, 32'd1);
      chk(out_result == v[32:1], rt, "result", out_result, v[32:1]);
      chk(out_illegal == v[0], "R8", "illegal flag", {31'b0, out_illegal}, {31'b0, v[0]});
    end
    tick();
    chk(out_valid == 1'b0, "R11", "idle after walk", {31'b0, out_valid}, 32'd0);
    tick();
    chk(out_valid == 1'b0, "R11", "still idle", {31'b0, out_valid}, 32'd0);

    // Back-to-back burst, in order (R11)
    drive(7'b0000010, 32'd2, 32'd3);
    tick();
    drive(7'b0000010, 32'd4, 32'd5);
    tick();
    chk(out_valid && out_result == 32'd6, "R11", "burst first", out_result, 32'd6);
    drive(7'b0000010, 32'd6, 32'd7);
    tick();
    in_valid = 1'b0;
    chk(out_valid && out_result == 32'd20, "R11", "burst second", out_result, 32'd20);
    tick();
    chk(out_valid && out_result == 32'd42, "R11", "burst third", out_result, 32'd42);
    tick();
    chk(out_valid == 1'b0, "R11", "burst drained", {31'b0, out_valid}, 32'd0);

    // Back-pressure (R10)
    out_ready = 1'b0;
    drive(7'b0000001, 32'd7, 32'd6);          // A -> 42
    tick();
    drive(7'b0000010, 32'h100, 32'h10);       // B -> 0x1000
    tick();
    chk(out_valid && out_result == 32'd42, "R10", "stalled result A", out_result, 32'd42);
    chk(in_ready == 1'b0, "R10", "in_ready low in stall", {31'b0, in_ready}, 32'd0);
    drive(7'b0000110, 32'h0003_0000, 32'h0005_0000); // C -> 15
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(out_valid && out_result == 32'd42, "R10", "result held", out_result, 32'd42);
      chk(in_ready == 1'b0, "R10", "in_ready held low", {31'b0, in_ready}, 32'd0);
    end
    out_ready = 1'b1;
    tick();
    in_valid = 1'b0;
    chk(out_valid && out_result == 32'h1000, "R10", "B after release", out_result, 32'h1000);
    tick();
    chk(out_valid && out_result == 32'd15, "R3", "C after release", out_result, 32'd15);
    tick();
    chk(out_valid == 1'b0, "R11", "no duplicate after release", {31'b0, out_valid}, 32'd0);

    // Shifted variant keeps low half clear with all-ones operands (R6)
    drive(7'b0001011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    tick();
    in_valid = 1'b0;
    tick();
    chk(out_result == 32'h0001_0000, "R6", "shift with all ones", out_result, 32'h0001_0000);
    tick();

    finish_run();
  end

endmodule